// File: doc/BRIEF.md
# System Exception State and Control Registers

This block holds the pending, active and enable state of eight fixed system exceptions: non-maskable interrupt (vector 2), memory fault (4), bus fault (5), usage fault (6), supervisor call (11), debug monitor (12), pendable service (14) and timer tick (15). It also holds the 8-bit priorities of vectors 4 to 15, a vector table base and a keyed reset request. Software reaches all of it through a simple word register bus. Hardware can raise pending state with one-cycle pulses. The exception entry and return logic reports each taken exception with an acknowledge strobe and each finished exception with a complete strobe, both carrying a vector number.

The block keeps a small stack of nested active vectors. From it, the control/state word reports the running vector and whether returning from it leads back to thread level. An external arbiter supplies the highest pending vector and an "any external interrupt pending" flag, which are reported in the same word. External interrupts use vector numbers 16 and up. They are tracked on the nesting stack but own no state here. Arbitration itself is done outside this block.

Top module: `sys_exc_regs`

## Requirements
- R1: After reset every pending and active bit is 0, every priority is 0, the vector base reads 0, the memory/bus/usage enables are 0 (excEnable = 0xF1), sysResetReq is 0, and the control/state word (address 0) reads 0x00000800 when pendVector and extPending are 0.
- R2: Writing address 0 with bit 31 set makes the NMI pending (excPending bit 0), and bit 31 of a read of address 0 reflects it.
- R3: At address 0, bit 28 sets and bit 27 clears the pendable-service pending bit (excPending bit 6, read back at bit 28). When both are 1, it ends up set.
- R4: At address 0, bit 26 sets and bit 25 clears the timer-tick pending bit (excPending bit 7, read back at bit 26). When both are 1, it ends up set.
- R5: A read of address 0 returns the running vector in bits 8:0, pendVector in bits 20:12 and extPending in bit 22.
- R6: Read bit 11 of address 0 is 1 when fewer than two exceptions are nested, and 0 otherwise. The running vector reads 0 when none is active.
- R7: An acknowledge of a system vector clears its pending bit, sets its active bit and makes it the running vector. A complete clears its active bit and returns the running vector to the preempted one.
- R8: A one-cycle pulse on hwSetPend bit i sets excPending bit i. Bit order is NMI, memory, bus, usage, supervisor call, debug, pendable service, tick (bits 0 to 7).
- R9: Address 6 reads active bits at 0 (memory), 1 (bus), 3 (usage), 7 (supervisor), 8 (debug), 10 (pendable service) and 11 (tick). It reads pending bits at 12 (usage), 13 (memory), 14 (bus) and 15 (supervisor). Writes change only the enables at 16 (memory), 17 (bus) and 18 (usage).
- R10: Addresses 3, 4 and 5 each hold four 8-bit priorities for vectors 4-7, 8-11 and 12-15, with the lowest vector in bits 7:0. excPrio carries the priority of vector 4+i in bits 8i+7:8i.
- R11: Address 1 holds the vector table base, and its low 7 bits always read 0.
- R12: A write to address 2 whose bits 31:16 equal 0x05FA and which has bit 2 or bit 0 set raises sysResetReq for exactly the following cycle. Any other write there leaves it low.
- R13: Acknowledging a vector of 16 or more makes it the running vector without touching any system exception bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| hwSetPend | input | 8 | Per-exception set-pending pulses |
| ackValid | input | 1 | Exception taken strobe |
| ackVector | input | VEC_W | Vector being taken |
| cmplValid | input | 1 | Exception finished strobe |
| cmplVector | input | VEC_W | Vector being finished |
| pendVector | input | VEC_W | Highest pending vector from the arbiter |
| extPending | input | 1 | Any external interrupt pending |
| excPending | output | 8 | Pending state per system exception |
| excActive | output | 8 | Active state per system exception |
| excEnable | output | 8 | Enable state per system exception |
| excPrio | output | 96 | Priorities of vectors 4 to 15 |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
A wrong pending or active bit appears on excPending or excActive on the cycle after the strobe that caused it. It also appears in the packed read words, which are checked bit by bit, so a bit in the wrong position or a lost set-over-clear rule shows up in the next register read. Nesting faults show up as a wrong running vector or a wrong return-to-base flag right after the acknowledge or complete. Key-check faults show up as a reset pulse that is missing, lasts too long, or appears without a valid key, one cycle after the write.

// File: rtl/sys_exc_pkg.sv
package sys_exc_pkg;
  localparam int NUM_EXC = 8;
  localparam int PRIO_W = 8;
  localparam int PRIO_REGS = 3;
  localparam int PRIO_LANES = 4;
  localparam int PRIO_BYTES = PRIO_REGS * PRIO_LANES;

  // register word indices
  localparam logic [2:0] ADDR_CTLSTATE = 3'd0;
  localparam logic [2:0] ADDR_VECBASE  = 3'd1;
  localparam logic [2:0] ADDR_RSTCTL   = 3'd2;
  localparam logic [2:0] ADDR_PRIO0    = 3'd3;
  localparam logic [2:0] ADDR_HANDLER  = 3'd6;

  localparam logic [15:0] RESET_KEY = 16'h05FA;

  // exception index order: NMI, mem, bus, usage, svc, debug, pendsv, tick
  localparam int IDX_NMI = 0;
  localparam int IDX_MEM = 1;
  localparam int IDX_BUS = 2;
  localparam int IDX_USAGE = 3;
  localparam int IDX_SVC = 4;
  localparam int IDX_DEBUG = 5;
  localparam int IDX_PENDSV = 6;
  localparam int IDX_TICK = 7;

  typedef struct packed {
    logic [NUM_EXC-1:0] pendSet;
    logic [NUM_EXC-1:0] pendClr;
    logic [NUM_EXC-1:0] actSet;
    logic [NUM_EXC-1:0] actClr;
    logic push;
    logic pop;
    logic wrVecBase;
    logic [PRIO_REGS-1:0] wrPrio;
    logic wrEnable;
    logic resetReq;
  } strobeT;

  // one-hot system exception mask for a vector number (0 for others)
  function automatic logic [NUM_EXC-1:0] vecToMask(input int unsigned vec);
    logic [NUM_EXC-1:0] m;
    m = '0;
    case (vec)
      2:  m[IDX_NMI] = 1'b1;
      4:  m[IDX_MEM] = 1'b1;
      5:  m[IDX_BUS] = 1'b1;
      6:  m[IDX_USAGE] = 1'b1;
      11: m[IDX_SVC] = 1'b1;
      12: m[IDX_DEBUG] = 1'b1;
      14: m[IDX_PENDSV] = 1'b1;
      15: m[IDX_TICK] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sys_exc_ctrl.sv
module sys_exc_ctrl
  import sys_exc_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic               busWe,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWdata,
  input  logic [NUM_EXC-1:0] hwSetPend,
  input  logic               ackValid,
  input  logic [VEC_W-1:0]   ackVector,
  input  logic               cmplValid,
  input  logic [VEC_W-1:0]   cmplVector,
  output strobeT             str
);
  logic wrCtl;
  logic [NUM_EXC-1:0] ackMask;
  logic [NUM_EXC-1:0] cmplMask;
  logic unusedWdata;

  assign unusedWdata = ^busWdata;
  assign wrCtl = busWe && (busAddr == ADDR_CTLSTATE);
  assign ackMask = ackValid ? vecToMask(int'(ackVector)) : '0;
  assign cmplMask = cmplValid ? vecToMask(int'(cmplVector)) : '0;

  always_comb begin
    str = '0;
    str.pendSet = hwSetPend;
    str.pendClr = ackMask;
    if (wrCtl) begin
      str.pendSet[IDX_NMI] = hwSetPend[IDX_NMI] | busWdata[31];
      str.pendSet[IDX_PENDSV] = hwSetPend[IDX_PENDSV] | busWdata[28];
      str.pendClr[IDX_PENDSV] = ackMask[IDX_PENDSV] | busWdata[27];
      str.pendSet[IDX_TICK] = hwSetPend[IDX_TICK] | busWdata[26];
      str.pendClr[IDX_TICK] = ackMask[IDX_TICK] | busWdata[25];
    end
    str.actSet = ackMask;
    str.actClr = cmplMask;
    str.push = ackValid;
    str.pop = cmplValid;
    str.wrVecBase = busWe && (busAddr == ADDR_VECBASE);
    for (int k = 0; k < PRIO_REGS; k++) begin
      str.wrPrio[k] = busWe && (busAddr == ADDR_PRIO0 + 3'(k));
    end
    str.wrEnable = busWe && (busAddr == ADDR_HANDLER);
    str.resetReq = busWe && (busAddr == ADDR_RSTCTL) &&
                   (busWdata[31:16] == RESET_KEY) &&
                   (busWdata[2] || busWdata[0]);
  end
endmodule

// File: rtl/sys_exc_dp.sv
module sys_exc_dp
  import sys_exc_pkg::*;
#(
  parameter int VEC_W = 9,
  parameter int NEST_DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobeT                       str,
  input  logic [2:0]                   busAddr,
  input  logic [31:0]                  busWdata,
  input  logic [VEC_W-1:0]             pushVec,
  input  logic [VEC_W-1:0]             pendVector,
  input  logic                         extPending,
  output logic [31:0]                  busRdata,
  output logic [NUM_EXC-1:0]           excPending,
  output logic [NUM_EXC-1:0]           excActive,
  output logic [NUM_EXC-1:0]           excEnable,
  output logic [PRIO_BYTES*PRIO_W-1:0] excPrio,
  output logic                         sysResetReq
);
  localparam int PTR_W = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;

  logic [NUM_EXC-1:0] pendQ;
  logic [NUM_EXC-1:0] activeQ;
  logic [2:0] enQ;
  logic [31:7] vecBaseQ;
  logic [PRIO_W-1:0] prioQ [PRIO_BYTES];
  logic [VEC_W-1:0] stackQ [NEST_DEPTH];
  logic [PTR_W:0] depthQ;
  logic [PTR_W-1:0] topIdx;
  logic stackFull;
  logic doPop;
  logic doPush;
  logic doReplace;
  logic [VEC_W-1:0] activeVec;
  logic retToBase;
  logic resetQ;

  // pending/active state: set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      activeQ <= '0;
      enQ <= '0;
      vecBaseQ <= '0;
      resetQ <= 1'b0;
    end else begin
      pendQ <= (pendQ & ~str.pendClr) | str.pendSet;
      activeQ <= (activeQ & ~str.actClr) | str.actSet;
      if (str.wrEnable) enQ <= busWdata[18:16];
      if (str.wrVecBase) vecBaseQ <= busWdata[31:7];
      resetQ <= str.resetReq;
    end
  end

  // priority bytes
  for (genvar r = 0; r < PRIO_REGS; r++) begin : g_prioReg
    for (genvar b = 0; b < PRIO_LANES; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN) prioQ[r*PRIO_LANES+b] <= '0;
        else if (str.wrPrio[r]) prioQ[r*PRIO_LANES+b] <= busWdata[b*PRIO_W +: PRIO_W];
      end
      assign excPrio[(r*PRIO_LANES+b)*PRIO_W +: PRIO_W] = prioQ[r*PRIO_LANES+b];
    end
  end

  // nesting stack of running vectors
  assign topIdx = PTR_W'(depthQ - 1'b1);
  assign stackFull = (depthQ == (PTR_W+1)'(NEST_DEPTH));
  assign doPop = str.pop && (depthQ != '0) && !str.push;
  assign doReplace = str.pop && (depthQ != '0) && str.push;
  assign doPush = str.push && !(str.pop && (depthQ != '0)) && !stackFull;

  always_ff @(posedge clk) begin
    if (!rstN) depthQ <= '0;
    else if (doPop) depthQ <= depthQ - 1'b1;
    else if (doPush) depthQ <= depthQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (doReplace) stackQ[topIdx] <= pushVec;
    else if (doPush) stackQ[depthQ[PTR_W-1:0]] <= pushVec;
  end

  assign activeVec = (depthQ == '0) ? '0 : stackQ[topIdx];
  assign retToBase = (depthQ <= (PTR_W+1)'(1));

  // read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CTLSTATE: begin
        busRdata[VEC_W-1:0] = activeVec;
        busRdata[11] = retToBase;
        busRdata[12 +: VEC_W] = pendVector;
        busRdata[22] = extPending;
        busRdata[26] = pendQ[IDX_TICK];
        busRdata[28] = pendQ[IDX_PENDSV];
        busRdata[31] = pendQ[IDX_NMI];
      end
      ADDR_VECBASE: busRdata[31:7] = vecBaseQ;
      ADDR_HANDLER: begin
        busRdata[0] = activeQ[IDX_MEM];
        busRdata[1] = activeQ[IDX_BUS];
        busRdata[3] = activeQ[IDX_USAGE];
        busRdata[7] = activeQ[IDX_SVC];
        busRdata[8] = activeQ[IDX_DEBUG];
        busRdata[10] = activeQ[IDX_PENDSV];
        busRdata[11] = activeQ[IDX_TICK];
        busRdata[12] = pendQ[IDX_USAGE];
        busRdata[13] = pendQ[IDX_MEM];
        busRdata[14] = pendQ[IDX_BUS];
        busRdata[15] = pendQ[IDX_SVC];
        busRdata[18:16] = enQ;
      end
      default: begin
        for (int k = 0; k < PRIO_REGS; k++) begin
          if (busAddr == ADDR_PRIO0 + 3'(k)) begin
            for (int b = 0; b < PRIO_LANES; b++) begin
              busRdata[b*PRIO_W +: PRIO_W] = prioQ[k*PRIO_LANES+b];
            end
          end
        end
      end
    endcase
  end

  assign excPending = pendQ;
  assign excActive = activeQ;
  assign excEnable = {4'b1111, enQ, 1'b1};
  assign sysResetReq = resetQ;

  // R2: an NMI set request always leaves the NMI pending
  p_nmi_set_r2 : assert property (@(posedge clk) disable iff (!rstN)
    str.pendSet[IDX_NMI] |=> excPending[IDX_NMI]);

  // R3: set and clear together leave pendable service pending
  p_set_wins_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (str.pendSet[IDX_PENDSV] && str.pendClr[IDX_PENDSV]) |=> excPending[IDX_PENDSV]);

  // R7: a completed vector is no longer active
  p_cmpl_clears_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (str.actClr != '0 && (str.actClr & str.actSet) == '0) |=> ((excActive & $past(str.actClr)) == '0));

  // R6: completing the last nested vector returns to thread level
  p_last_pop_r6 : assert property (@(posedge clk) disable iff (!rstN)
    (str.pop && !str.push && depthQ == (PTR_W+1)'(1)) |=> (activeVec == '0 && retToBase));
endmodule

// File: rtl/sys_exc_regs.sv
module sys_exc_regs
  import sys_exc_pkg::*;
#(
  parameter int VEC_W = 9,
  parameter int NEST_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [2:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [7:0]        hwSetPend,
  input  logic              ackValid,
  input  logic [VEC_W-1:0]  ackVector,
  input  logic              cmplValid,
  input  logic [VEC_W-1:0]  cmplVector,
  input  logic [VEC_W-1:0]  pendVector,
  input  logic              extPending,
  output logic [7:0]        excPending,
  output logic [7:0]        excActive,
  output logic [7:0]        excEnable,
  output logic [95:0]       excPrio,
  output logic              sysResetReq
);
  strobeT str;

  sys_exc_ctrl #(.VEC_W(VEC_W)) u_ctrl (
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .hwSetPend(hwSetPend), .ackValid(ackValid), .ackVector(ackVector),
    .cmplValid(cmplValid), .cmplVector(cmplVector), .str(str)
  );

  sys_exc_dp #(.VEC_W(VEC_W), .NEST_DEPTH(NEST_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .busAddr(busAddr), .busWdata(busWdata),
    .pushVec(ackVector), .pendVector(pendVector), .extPending(extPending),
    .busRdata(busRdata), .excPending(excPending), .excActive(excActive),
    .excEnable(excEnable), .excPrio(excPrio), .sysResetReq(sysResetReq)
  );

  // R12: a reset request only follows a keyed write to the reset control word
  p_key_gate_r12 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetReq) |-> $past(busWe && busAddr == ADDR_RSTCTL && busWdata[31:16] == RESET_KEY));
endmodule

// File: tb/sys_exc_regs_tb.sv
`timescale 1ns/1ps
module sys_exc_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0] hwSetPend = '0;
  logic ackValid = 1'b0;
  logic [8:0] ackVector = '0;
  logic cmplValid = 1'b0;
  logic [8:0] cmplVector = '0;
  logic [8:0] pendVector = '0;
  logic extPending = 1'b0;
  logic [7:0] excPending;
  logic [7:0] excActive;
  logic [7:0] excEnable;
  logic [95:0] excPrio;
  logic sysResetReq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sys_exc_regs u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .hwSetPend(hwSetPend), .ackValid(ackValid),
    .ackVector(ackVector), .cmplValid(cmplValid), .cmplVector(cmplVector),
    .pendVector(pendVector), .extPending(extPending), .excPending(excPending),
    .excActive(excActive), .excEnable(excEnable), .excPrio(excPrio),
    .sysResetReq(sysResetReq)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic pulseHw(input logic [7:0] m);
    @(negedge clk); hwSetPend = m;
    @(negedge clk); hwSetPend = '0;
  endtask

  task automatic doAck(input int v);
    @(negedge clk); ackValid = 1'b1; ackVector = 9'(v);
    @(negedge clk); ackValid = 1'b0;
  endtask

  task automatic doCmpl(input int v);
    @(negedge clk); cmplValid = 1'b1; cmplVector = 9'(v);
    @(negedge clk); cmplValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    doRead(3'd0, d); chk("R1 ctlState", 96'(d), 96'h800);
    doRead(3'd6, d); chk("R1 handler", 96'(d), 96'h0);
    doRead(3'd1, d); chk("R1 vecBase", 96'(d), 96'h0);
    chk("R1 pending", 96'(excPending), 96'h0);
    chk("R1 active", 96'(excActive), 96'h0);
    chk("R1 enable", 96'(excEnable), 96'hF1);
    chk("R1 prio", excPrio, 96'h0);
    chk("R1 resetReq", 96'(sysResetReq), 96'h0);
  endtask

  task automatic testCtlWrites();
    logic [31:0] d;
    doWrite(3'd0, 32'h8000_0000);
    chk("R2 nmi pending", 96'(excPending), 96'h01);
    doRead(3'd0, d); chk("R2 nmi readback", 96'(d[31]), 96'h1);
    doWrite(3'd0, 32'h1400_0000);
    chk("R3 R4 set both", 96'(excPending), 96'hC1);
    doWrite(3'd0, 32'h1800_0000);
    chk("R3 set wins", 96'(excPending[6]), 96'h1);
    doWrite(3'd0, 32'h0800_0000);
    chk("R3 clear", 96'(excPending[6]), 96'h0);
    doWrite(3'd0, 32'h0600_0000);
    chk("R4 set wins", 96'(excPending[7]), 96'h1);
    doRead(3'd0, d); chk("R4 tick readback", 96'(d[26]), 96'h1);
    doWrite(3'd0, 32'h0200_0000);
    chk("R4 clear", 96'(excPending[7]), 96'h0);
    doRead(3'd0, d); chk("R2 R3 R4 word", 96'(d), 96'h8000_0800);
  endtask

  task automatic testStatusFields();
    logic [31:0] d;
    pendVector = 9'h25; extPending = 1'b1;
    doRead(3'd0, d);
    chk("R5 fields", 96'(d), 96'(32'h8000_0800 | (32'h25 << 12) | (32'h1 << 22)));
    pendVector = '0; extPending = 1'b0;
  endtask

  task automatic testHwSet();
    logic [31:0] d;
    pulseHw(8'b0001_1110);
    chk("R8 hw pending", 96'(excPending), 96'h1F);
    doRead(3'd6, d); chk("R9 pending bits", 96'(d), 96'hF000);
  endtask

  task automatic testNesting();
    logic [31:0] d;
    doAck(11);
    chk("R7 ack svc pend", 96'(excPending[4]), 96'h0);
    chk("R7 ack svc act", 96'(excActive), 96'h10);
    doRead(3'd0, d); chk("R6 R7 one level", 96'({d[11], d[8:0]}), 96'({1'b1, 9'd11}));
    doRead(3'd6, d); chk("R9 svc active bit", 96'(d[7]), 96'h1);
    doAck(4);
    doRead(3'd0, d); chk("R6 R7 nested", 96'({d[11], d[8:0]}), 96'({1'b0, 9'd4}));
    doRead(3'd6, d); chk("R9 mem active bit", 96'(d[0]), 96'h1);
    doCmpl(4);
    chk("R7 cmpl mem", 96'(excActive), 96'h10);
    doRead(3'd0, d); chk("R6 R7 back to svc", 96'({d[11], d[8:0]}), 96'({1'b1, 9'd11}));
    doCmpl(11);
    chk("R7 cmpl svc", 96'(excActive), 96'h0);
    doRead(3'd0, d); chk("R6 idle", 96'({d[11], d[8:0]}), 96'({1'b1, 9'd0}));
    doAck(2);
    chk("R7 ack nmi clears pending", 96'(excPending), 96'h0C);
    doCmpl(2);
    chk("R7 cmpl nmi", 96'(excActive), 96'h0);
  endtask

  task automatic testExternal();
    logic [31:0] d;
    doAck(20);
    doRead(3'd0, d); chk("R13 ext running", 96'(d[8:0]), 96'd20);
    chk("R13 no active touch", 96'(excActive), 96'h0);
    chk("R13 no pending touch", 96'(excPending), 96'h0C);
    doCmpl(20);
    doRead(3'd0, d); chk("R13 ext done", 96'(d[8:0]), 96'd0);
  endtask

  task automatic testHandlerWrite();
    logic [31:0] d;
    doWrite(3'd6, 32'hFFFF_FFFF);
    doRead(3'd6, d); chk("R9 write enables only", 96'(d), 96'h0007_5000);
    chk("R9 enable out", 96'(excEnable), 96'hFF);
    chk("R9 pending kept", 96'(excPending), 96'h0C);
    doWrite(3'd6, 32'h0002_0000);
    chk("R9 bus only", 96'(excEnable), 96'hF5);
  endtask

  task automatic testPrio();
    logic [31:0] d;
    doWrite(3'd3, 32'h4433_2211);
    doWrite(3'd4, 32'h8877_6655);
    doWrite(3'd5, 32'hCCBB_AA99);
    chk("R10 packed out", excPrio, 96'hCCBBAA99_88776655_44332211);
    doRead(3'd4, d); chk("R10 readback", 96'(d), 96'h8877_6655);
    doWrite(3'd4, 32'h0000_00F0);
    chk("R10 vector 8 lane", 96'(excPrio[39:32]), 96'hF0);
  endtask

  task automatic testVecBase();
    logic [31:0] d;
    doWrite(3'd1, 32'hFFFF_FFFF);
    doRead(3'd1, d); chk("R11 aligned", 96'(d), 96'hFFFF_FF80);
  endtask

  task automatic testResetCtl();
    doWrite(3'd2, 32'h05FA_0004);
    chk("R12 pulse bit2", 96'(sysResetReq), 96'h1);
    @(negedge clk); chk("R12 one cycle", 96'(sysResetReq), 96'h0);
    doWrite(3'd2, 32'h05FA_0001);
    chk("R12 pulse bit0", 96'(sysResetReq), 96'h1);
    doWrite(3'd2, 32'h1234_0005);
    chk("R12 bad key", 96'(sysResetReq), 96'h0);
    doWrite(3'd2, 32'h05FA_0002);
    chk("R12 no request bit", 96'(sysResetReq), 96'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtlWrites();
    testStatusFields();
    testHwSet();
    testNesting();
    testExternal();
    testHandlerWrite();
    testPrio();
    testVecBase();
    testResetCtl();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule